// File: doc/BRIEF.md
# Periodic Tick Timer with Atomic Register Aliases

This block is a memory-mapped 16-bit up-counter that produces a periodic system tick interrupt. Software sets a terminal value in the period register and turns the timer on. The counter then advances once per prescaled tick. When it has reached the terminal value, the next tick returns it to zero and latches an interrupt request. That request stays asserted until software acknowledges it.

The tick source is selectable. It can be an internal clock-enable strobe or an external clock pin, which is synchronized and reduced to rising edges. A sparse prescaler divides the tick by 1, 8, 64 or 256.

Each of the three registers (control, count, period) occupies four consecutive words on a word-addressed bus. The first word is a plain write. The second clears the bits that are set in the write data, the third sets them and the fourth toggles them. Software can therefore change single bits without a read-modify-write sequence.

Top module: `tick_timer`

## Requirements
- R1: After synchronous reset the control register reads 0, the count reads 0, the period reads 0xFFFF and `irq` is low.
- R2: Word offset 0 of a register replaces it. Offset 1 clears the bits that are 1 in the data, offset 2 sets them and offset 3 inverts them; all other bits are unchanged. Control is at words 0–3, count at 4–7 and period at 8–11.
- R3: Count and period hold 16 bits. The control register keeps only bit 15 (enable), bits 5:4 (prescale code), bit 1 (source) and bit 0 (pending). Every other bit, and bits 31:16 of count and period, read as zero and ignore writes.
- R4: A read of any alias word returns its base register. `reg_rdata` shows the register addressed in the previous cycle.
- R5: On each prescaled tick the count increments. A tick taken while the count equals the period returns the count to 0, so one full cycle lasts period+1 prescaled ticks.
- R6: Each return to zero sets the pending flag (control bit 0), and `irq` follows that flag.
- R7: The pending flag stays set until software clears it, for example by writing 1 to bit 0 through the clear alias of control.
- R8: While enable (control bit 15) is 0, the count holds its value and no wrap occurs.
- R9: Prescale code 0, 1, 2 and 3 in control bits 5:4 gives one counter step per 1, 8, 64 or 256 source ticks respectively.
- R10: Any write to a control alias restarts the prescaler from zero.
- R11: Source bit 1 = 0 takes ticks from `pclk_en`; bit 1 = 1 takes one tick per rising edge of `ext_clk`, seen through a two-flop synchronizer. The unselected input has no effect.
- R12: If a wrap and a software clear of the pending flag fall in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Word address: bits 3:2 select the register, bits 1:0 the alias |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data of the register addressed last cycle |
| pclk_en | input | 1 | Internal tick strobe, one cycle per source tick |
| ext_clk | input | 1 | External clock, asynchronous to `clk` |
| irq | output | 1 | Pending tick interrupt |

## Verification
On every cycle, the embedded assertions check these properties. The count holds when no tick arrives and returns to zero on a tick at the terminal value. A wrap always leaves `irq` set on the next cycle, and `irq` only falls after a control write. No wrap occurs while the timer is disabled. The prescaler advances by one on each source tick it does not pass through. The synchronized edge is one cycle wide, and the upper half of read data stays zero. The alias arithmetic needs the directed scenarios. So do the exact prescale ratios, the prescaler restart on a control write, the ignoring of the unselected source, and the collision of a wrap with a clear. Each of these depends on a sequence of bus writes followed by a counted number of ticks.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SET   = 2'd2,
    OP_FLIP  = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    RG_CTRL   = 2'd0,
    RG_COUNT  = 2'd1,
    RG_PERIOD = 2'd2,
    RG_NONE   = 2'd3
  } reg_sel_e;

  localparam int B_PEND = 0;
  localparam int B_SRC  = 1;
  localparam int B_PS   = 4;
  localparam int B_ON   = 15;
  localparam logic [REG_W-1:0] CTRL_KEEP = 32'h0000_8033;

  function automatic logic [REG_W-1:0] alias_apply32(input logic [REG_W-1:0] cur,
                                                      input logic [REG_W-1:0] wd,
                                                      input alias_op_e op);
    case (op)
      OP_CLEAR: return cur & ~wd;
      OP_SET:   return cur | wd;
      OP_FLIP:  return cur ^ wd;
      default:  return wd;
    endcase
  endfunction

  function automatic int unsigned ps_terminal(input logic [1:0] code);
    case (code)
      2'd1:    return 7;
      2'd2:    return 63;
      2'd3:    return 255;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      rise  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-1:0], async_in};
      rise  <= chain[LAST] & ~chain[STAGES];
    end
  end

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R11
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale
  import tick_timer_pkg::*;
#(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       tick_in,
  input  logic [1:0] code,
  output logic       tick_out
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] term;

  assign term     = PS_W'(ps_terminal(code));
  assign tick_out = tick_in && (pcnt >= term);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else if (tick_in) begin
      if (pcnt >= term) pcnt <= '0;
      else              pcnt <= pcnt + 1'b1;
    end
  end

  AST_PS_STEP: assert property (@(posedge clk) disable iff (rst)
    (!restart && tick_in && !tick_out) |=> (pcnt == $past(pcnt) + 1'b1)); // R9
endmodule

// File: rtl/tick_count_core.sv
module tick_count_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic at_top;

  assign at_top = (cnt == period);
  assign wrap   = tick && !load && at_top;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= at_top ? '0 : cnt + 1'b1;
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt)); // R8
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && cnt == period) |=> (cnt == '0)); // R5
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PS_W        = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              pclk_en,
  input  logic              ext_clk,
  output logic              irq
);
  localparam int PAD_W = REG_W - CNT_W;

  function automatic logic [CNT_W-1:0] alias_n(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] wd,
                                                input alias_op_e op);
    case (op)
      OP_CLEAR: return cur & ~wd;
      OP_SET:   return cur | wd;
      OP_FLIP:  return cur ^ wd;
      default:  return wd;
    endcase
  endfunction

  reg_sel_e         rsel;
  alias_op_e        aop;
  logic             wr_ctrl, wr_count, wr_period;
  logic [REG_W-1:0] ctrl_q, ctrl_next;
  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_load_val;
  logic             ext_rise, src_tick, ps_in, ps_tick, wrap;

  assign rsel      = reg_sel_e'(reg_addr[ADDR_W-1:ADDR_W-2]);
  assign aop       = alias_op_e'(reg_addr[1:0]);
  assign wr_ctrl   = reg_we && (rsel == RG_CTRL);
  assign wr_count  = reg_we && (rsel == RG_COUNT);
  assign wr_period = reg_we && (rsel == RG_PERIOD);

  tick_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_clk),
    .rise     (ext_rise)
  );

  assign src_tick = ctrl_q[B_SRC] ? ext_rise : pclk_en;
  assign ps_in    = ctrl_q[B_ON] && src_tick;

  tick_prescale #(.PS_W(PS_W)) u_ps (
    .clk      (clk),
    .rst      (rst),
    .restart  (wr_ctrl),
    .tick_in  (ps_in),
    .code     (ctrl_q[B_PS+1:B_PS]),
    .tick_out (ps_tick)
  );

  assign cnt_load_val = alias_n(cnt, reg_wdata[CNT_W-1:0], aop);

  tick_count_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (ps_tick),
    .load     (wr_count),
    .load_val (cnt_load_val),
    .period   (period_q),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  always_comb begin
    ctrl_next = ctrl_q;
    if (wr_ctrl) ctrl_next = alias_apply32(ctrl_q, reg_wdata, aop) & CTRL_KEEP;
    if (wrap)    ctrl_next[B_PEND] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
    end else begin
      ctrl_q <= ctrl_next;
      if (wr_period) period_q <= alias_n(period_q, reg_wdata[CNT_W-1:0], aop);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (rsel)
        RG_CTRL:   reg_rdata <= ctrl_q;
        RG_COUNT:  reg_rdata <= {{PAD_W{1'b0}}, cnt};
        RG_PERIOD: reg_rdata <= {{PAD_W{1'b0}}, period_q};
        default:   reg_rdata <= '0;
      endcase
    end
  end

  assign irq = ctrl_q[B_PEND];

  AST_WRAP_PENDS: assert property (@(posedge clk) disable iff (rst)
    wrap |=> irq); // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    $fell(irq) |-> $past(wr_ctrl)); // R7
  AST_OFF_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q[B_ON] |-> !wrap); // R8
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:CNT_W] == '0); // R3
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  localparam logic [3:0] A_CTRL = 4'd0, A_CTRL_CLR = 4'd1, A_CTRL_SET = 4'd2, A_CTRL_INV = 4'd3;
  localparam logic [3:0] A_CNT = 4'd4;
  localparam logic [3:0] A_PER = 4'd8, A_PER_CLR = 4'd9, A_PER_SET = 4'd10, A_PER_INV = 4'd11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pclk_en = 1'b0;
  logic        ext_clk = 1'b0;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pclk_en   (pclk_en),
    .ext_clk   (ext_clk),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); pclk_en = 1'b1;
      @(negedge clk); pclk_en = 1'b0;
    end
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(negedge clk);
      ext_clk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v);  check("R1 ctrl after reset", v, 32'h0);
    rd(A_CNT, v);   check("R1 count after reset", v, 32'h0);
    rd(A_PER, v);   check("R1 period after reset", v, 32'h0000_FFFF);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_alias;
    logic [31:0] v;
    wr(A_PER, 32'h1234);      rd(A_PER, v); check("R2 base write", v, 32'h1234);
    wr(A_PER_SET, 32'h0F00);  rd(A_PER, v); check("R2 set alias", v, 32'h1F34);
    wr(A_PER_CLR, 32'h0004);  rd(A_PER, v); check("R2 clear alias", v, 32'h1F30);
    wr(A_PER_INV, 32'h00FF);  rd(A_PER, v); check("R2 invert alias", v, 32'h1FCF);
  endtask

  task automatic t_width;
    logic [31:0] v;
    wr(A_PER, 32'hABCD_1234); rd(A_PER, v);  check("R3 period upper bits", v, 32'h1234);
    wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, v); check("R3 ctrl kept bits", v, 32'h8033);
    wr(A_CTRL, 32'h0);        rd(A_CTRL, v);  check("R3 ctrl cleared", v, 32'h0);
  endtask

  task automatic t_alias_read;
    logic [31:0] v;
    wr(A_PER, 32'h5A5A);
    rd(4'd9, v);  check("R4 read clear alias", v, 32'h5A5A);
    rd(4'd10, v); check("R4 read set alias", v, 32'h5A5A);
    rd(4'd11, v); check("R4 read invert alias", v, 32'h5A5A);
  endtask

  task automatic t_count_wrap;
    logic [31:0] v;
    wr(A_CTRL, 32'h0); wr(A_PER, 32'd4); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h8000);
    pulses(3);
    rd(A_CNT, v); check("R5 count after 3 ticks", v, 32'd3);
    check("R6 no irq before wrap", {31'b0, irq}, 32'h0);
    pulses(2);
    rd(A_CNT, v); check("R5 wrap after period+1 ticks", v, 32'd0);
    check("R6 irq after wrap", {31'b0, irq}, 32'h1);
    rd(A_CTRL, v); check("R6 pending bit0", v, 32'h8001);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    repeat (10) @(negedge clk);
    check("R7 irq held", {31'b0, irq}, 32'h1);
    wr(A_CTRL_CLR, 32'h1);
    check("R7 irq cleared", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); check("R7 other ctrl bits kept", v, 32'h8000);
  endtask

  task automatic t_disable;
    logic [31:0] v;
    pulses(2);
    rd(A_CNT, v); check("R8 count before disable", v, 32'd2);
    wr(A_CTRL_CLR, 32'h8000);
    pulses(5);
    rd(A_CNT, v); check("R8 count holds while off", v, 32'd2);
    check("R8 no irq while off", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_prescale;
    logic [31:0] v;
    for (int code = 1; code < 4; code++) begin
      int ratio;
      ratio = (code == 1) ? 8 : (code == 2) ? 64 : 256;
      wr(A_CTRL, 32'h0); wr(A_PER, 32'hFFFF); wr(A_CNT, 32'd0);
      wr(A_CTRL, 32'h8000 | (32'(code) << 4));
      pulses(ratio - 1);
      rd(A_CNT, v); check($sformatf("R9 code %0d one short", code), v, 32'd0);
      pulses(1);
      rd(A_CNT, v); check($sformatf("R9 code %0d full ratio", code), v, 32'd1);
    end
  endtask

  task automatic t_ps_restart;
    logic [31:0] v;
    wr(A_CTRL, 32'h0); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h8010);
    pulses(5);
    wr(A_CTRL_SET, 32'h0);
    pulses(7);
    rd(A_CNT, v); check("R10 prescaler restarted", v, 32'd0);
    pulses(1);
    rd(A_CNT, v); check("R10 step after restart", v, 32'd1);
  endtask

  task automatic t_ext_src;
    logic [31:0] v;
    wr(A_CTRL, 32'h0); wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h8002);
    pulses(4);
    rd(A_CNT, v); check("R11 pclk_en ignored on ext source", v, 32'd0);
    ext_edges(3);
    rd(A_CNT, v); check("R11 ext rising edges counted", v, 32'd3);
    wr(A_CTRL, 32'h8000);
    ext_edges(2);
    rd(A_CNT, v); check("R11 ext ignored on internal source", v, 32'd3);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(A_CTRL, 32'h0); wr(A_PER, 32'd2); wr(A_CNT, 32'd2);
    wr(A_CTRL, 32'h8001);
    @(negedge clk);
    pclk_en = 1'b1; reg_we = 1'b1; reg_addr = A_CTRL_CLR; reg_wdata = 32'h1;
    @(negedge clk);
    pclk_en = 1'b0; reg_we = 1'b0;
    check("R12 pending survives clear on wrap", {31'b0, irq}, 32'h1);
    rd(A_CNT, v); check("R12 count wrapped", v, 32'd0);
    wr(A_CTRL_CLR, 32'h1);
    check("R12 later clear works", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alias();
    t_width();
    t_alias_read();
    t_count_wrap();
    t_sticky();
    t_disable();
    t_prescale();
    t_ps_restart();
    t_ext_src();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule